// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block is a read-only, direct-mapped cache that sits between a single requester and a slower word-wide backing memory. The requester presents byte addresses. Each address is cut into four fields: the low bits pick a byte within a word and play no part in the lookup, the next bits pick a word within a block, the next bits pick one cache line, and the remaining high bits form the tag. A block can live in only one line, the one whose number equals the block number modulo the line count.

An accepted request is looked up one cycle later. The word picked by the index and word offset is read from the data array at the same time as the stored tag is compared, and the response qualifies that word with the hit result. On a miss the controller reads the whole block from the backing memory over a valid/ready handshake, one word per handshake in ascending order from word offset 0. It then stores the tag, marks the line valid and repeats the lookup, which now hits and returns the word. While a request is in flight the block takes no new request. Block size and line count are parameters.

Top module: `dm_read_cache`

## Requirements
- R1: The two lowest address bits (byte within a 4-byte word) have no effect on lookup: addresses that differ only in those bits return the same word, and after one of them has been loaded the others hit.
- R2: With byte offset b = log2(WORD_W/8) and word-offset width w = log2(BLOCK_WORDS), the line index is address bits [b+w +: log2(LINES)], which equals the block number modulo LINES. The tag is all the bits above the index.
- R3: A lookup hits exactly when the indexed line is valid and its stored tag equals the address tag. A hit response has resp_miss = 0 and a miss response has resp_miss = 1.
- R4: After reset req_ready = 1, resp_valid = 0, mem_req_valid = 0 and every line is invalid, so the first access to any block misses, including an access after a second reset.
- R5: A miss fetches all BLOCK_WORDS words of the block, one per mem_ready handshake, at byte addresses base, base+4, base+8 and so on in ascending order, where base is the request address with its offset bits cleared. mem_addr is held stable until each handshake.
- R6: After a miss refill, an access to any other word of the same block hits with no memory traffic.
- R7: req_ready is low from the cycle after a request is accepted until the response has been given. A req_valid raised during that time is ignored: it causes no fetch, no response, and leaves no entry in the cache.
- R8: A hit responds in the cycle right after acceptance. Every response has resp_valid high for exactly one cycle. A miss responds after the last word of the refill.
- R9: Two blocks with the same index and different tags evict each other, so alternating between them misses on every access.
- R10: When resp_valid is high, resp_data equals the backing-memory word at the requested word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | WORD_W | Requested word, valid with resp_valid |
| resp_miss | output | 1 | Response needed a refill |
| mem_req_valid | output | 1 | Refill word read request |
| mem_addr | output | ADDR_W | Byte address of the refill word |
| mem_ready | input | 1 | Memory supplies mem_rdata this cycle |
| mem_rdata | input | WORD_W | Refill word from memory |

## Verification
The default configuration (4 lines, 2-word blocks) is driven with a short sequential word string whose hit/miss pattern tells block-level locality apart from word-level caching. An alternating pair of same-index blocks separates index from tag decoding. A sweep over 64 consecutive words, run with a cold cache and then again with a warm one, covers every index and several tags. That pass tells apart a wrong modulo mapping, a wrong tag compare and a refill that skips or reorders words. Byte-offset variants of one word, a second reset and stray requests during a refill cover the cases where an input must have no effect. Memory latency is varied between 0 and 3 cycles so that handshake timing cannot mask a fault.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_REFILL = 2'd2
   } dmc_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W = 32,
   parameter int BYTE_W = 2,
   parameter int WOFF_W = 1,
   parameter int CNT_W  = 1,
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 27
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [TAG_W-1:0]  tag_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [CNT_W-1:0]  woff_o
);
   localparam int LOW_W = BYTE_W + WOFF_W;

   assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
   assign idx_o = addr_i[LOW_W +: IDX_W];

   generate
      if (WOFF_W > 0) begin : g_multi
         assign woff_o = addr_i[BYTE_W +: WOFF_W];
      end else begin : g_single
         assign woff_o = '0;
      end
   endgenerate

   logic unused_byte_bits;
   assign unused_byte_bits = ^addr_i[BYTE_W-1:0];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 4,
   parameter int IDX_W = 2,
   parameter int TAG_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             fill_done_i,
   output logic             hit_o
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (fill_done_i) begin
         valid_q[idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done_i) begin
         tag_q[idx_i] <= tag_i;
      end
   end

   assign hit_o = valid_q[idx_i] && (tag_q[idx_i] == tag_i);

   // R4
   reset_all_invalid_chk: assert property (@(posedge clk)
      $fell(rst_n) |=> (valid_q == '0));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int LINES       = 4,
   parameter int BLOCK_WORDS = 2,
   parameter int WORD_W      = 32,
   parameter int IDX_W       = 2,
   parameter int CNT_W       = 1
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [CNT_W-1:0]  rd_word_i,
   input  logic              wr_en_i,
   input  logic [CNT_W-1:0]  wr_word_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [WORD_W-1:0] rd_data_o
);
   logic [WORD_W-1:0] cell_q [LINES][BLOCK_WORDS];

   generate
      if (BLOCK_WORDS > 1) begin : g_multi
         always_ff @(posedge clk) begin
            if (wr_en_i) begin
               cell_q[idx_i][wr_word_i] <= wr_data_i;
            end
         end
         assign rd_data_o = cell_q[idx_i][rd_word_i];
      end else begin : g_single
         always_ff @(posedge clk) begin
            if (wr_en_i) begin
               cell_q[idx_i][0] <= wr_data_i;
            end
         end
         assign rd_data_o = cell_q[idx_i][0];
         logic unused_word_sel;
         assign unused_word_sel = ^{rd_word_i, wr_word_i};
      end
   endgenerate
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_WORDS = 2,
   parameter int CNT_W       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              req_ready_o,
   output logic              resp_valid_o,
   output logic              resp_miss_o,
   input  logic              hit_i,
   output logic              mem_req_valid_o,
   input  logic              mem_ready_i,
   output logic [ADDR_W-1:0] addr_q_o,
   output logic [CNT_W-1:0]  fill_cnt_o,
   output logic              wr_en_o,
   output logic              fill_done_o
);
   localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(BLOCK_WORDS - 1);

   dmc_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              miss_q;
   logic              last_beat;

   assign last_beat = (cnt_q == LAST_WORD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cnt_q   <= '0;
         miss_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  addr_q  <= req_addr_i;
                  miss_q  <= 1'b0;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (hit_i) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q   <= '0;
                  miss_q  <= 1'b1;
                  state_q <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (mem_ready_i) begin
                  if (last_beat) begin
                     state_q <= ST_LOOKUP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o     = (state_q == ST_IDLE);
   assign resp_valid_o    = (state_q == ST_LOOKUP) && hit_i;
   assign resp_miss_o     = miss_q;
   assign mem_req_valid_o = (state_q == ST_REFILL);
   assign wr_en_o         = (state_q == ST_REFILL) && mem_ready_i;
   assign fill_done_o     = wr_en_o && last_beat;
   assign addr_q_o        = addr_q;
   assign fill_cnt_o      = cnt_q;

   // R7
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready_o && req_valid_i) |=> !req_ready_o);

   // R7
   refill_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> !req_ready_o);

   // R8
   single_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid_o |=> !resp_valid_o);
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache
   import dmc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int LINES       = 4,
   parameter int BLOCK_WORDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [WORD_W-1:0] resp_data,
   output logic              resp_miss,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int BYTE_W = $clog2(WORD_W / 8);
   localparam int WOFF_W = $clog2(BLOCK_WORDS);
   localparam int CNT_W  = (WOFF_W > 0) ? WOFF_W : 1;
   localparam int IDX_W  = $clog2(LINES);
   localparam int LOW_W  = BYTE_W + WOFF_W;
   localparam int TAG_W  = ADDR_W - LOW_W - IDX_W;
   localparam int WORD_BYTES = WORD_W / 8;

   generate
      if (!is_pow2(LINES) || LINES < 2) begin : g_bad_lines
         $error("LINES must be a power of two and at least 2");
      end
      if (!is_pow2(BLOCK_WORDS)) begin : g_bad_block
         $error("BLOCK_WORDS must be a power of two");
      end
      if (WORD_W < 16 || !is_pow2(WORD_W / 8) || (WORD_W % 8) != 0) begin : g_bad_word
         $error("WORD_W must be a power-of-two byte count of at least 2 bytes");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("address too narrow for the chosen geometry");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [TAG_W-1:0]  lk_tag;
   logic [IDX_W-1:0]  lk_idx;
   logic [CNT_W-1:0]  lk_woff;
   logic [CNT_W-1:0]  fill_cnt;
   logic              lk_hit;
   logic              wr_en;
   logic              fill_done;

   dmc_ctrl #(
      .ADDR_W      (ADDR_W),
      .BLOCK_WORDS (BLOCK_WORDS),
      .CNT_W       (CNT_W)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid_i     (req_valid),
      .req_addr_i      (req_addr),
      .req_ready_o     (req_ready),
      .resp_valid_o    (resp_valid),
      .resp_miss_o     (resp_miss),
      .hit_i           (lk_hit),
      .mem_req_valid_o (mem_req_valid),
      .mem_ready_i     (mem_ready),
      .addr_q_o        (addr_q),
      .fill_cnt_o      (fill_cnt),
      .wr_en_o         (wr_en),
      .fill_done_o     (fill_done)
   );

   dmc_addr_split #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W),
      .WOFF_W (WOFF_W),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W)
   ) u_split (
      .addr_i (addr_q),
      .tag_o  (lk_tag),
      .idx_o  (lk_idx),
      .woff_o (lk_woff)
   );

   dmc_tag_store #(
      .LINES (LINES),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx_i       (lk_idx),
      .tag_i       (lk_tag),
      .fill_done_i (fill_done),
      .hit_o       (lk_hit)
   );

   dmc_data_store #(
      .LINES       (LINES),
      .BLOCK_WORDS (BLOCK_WORDS),
      .WORD_W      (WORD_W),
      .IDX_W       (IDX_W),
      .CNT_W       (CNT_W)
   ) u_data (
      .clk       (clk),
      .idx_i     (lk_idx),
      .rd_word_i (lk_woff),
      .wr_en_i   (wr_en),
      .wr_word_i (fill_cnt),
      .wr_data_i (mem_rdata),
      .rd_data_o (resp_data)
   );

   generate
      if (WOFF_W > 0) begin : g_addr_multi
         assign mem_addr = {addr_q[ADDR_W-1:LOW_W], fill_cnt, {BYTE_W{1'b0}}};
      end else begin : g_addr_single
         assign mem_addr = {addr_q[ADDR_W-1:LOW_W], {BYTE_W{1'b0}}};
         logic unused_cnt;
         assign unused_cnt = ^fill_cnt;
      end
   endgenerate

   // R5
   fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_ready) |=> (mem_req_valid && $stable(mem_addr)));

   // R5
   fetch_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_ready && !fill_done) |=>
         (mem_req_valid && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

   // R5
   fetch_starts_at_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> (mem_addr[LOW_W-1:0] == '0));

   // R8
   miss_resp_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> (resp_valid && resp_miss));
endmodule

// File: tb/tb_dm_read_cache.sv
module tb_dm_read_cache;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int WORD_W = 32;
   localparam int LINES = 4;
   localparam int BLOCK_WORDS = 2;
   localparam int BLK_BYTES = BLOCK_WORDS * 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_ready;
   logic              resp_valid;
   logic [WORD_W-1:0] resp_data;
   logic              resp_miss;
   logic              mem_req_valid;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ready = 1'b0;
   logic [WORD_W-1:0] mem_rdata = '0;

   int checks = 0;
   int fails = 0;
   int mem_lat = 0;
   int wait_cnt = 0;
   int fetch_n = 0;
   logic [ADDR_W-1:0] fetch_log [16];
   bit ref_valid [LINES];
   int ref_tag [LINES];
   int miss_total = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dm_read_cache #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .BLOCK_WORDS(BLOCK_WORDS)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .resp_valid(resp_valid), .resp_data(resp_data), .resp_miss(resp_miss),
      .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] byte_addr);
      logic [31:0] w;
      w = byte_addr >> 2;
      return (w * 32'h9E37_79B1) + 32'h0BAD_F00D;
   endfunction

   // Backing memory: answers after mem_lat idle cycles, logs each fetch.
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ready = 1'b0;
         wait_cnt = 0;
      end else begin
         if (mem_ready) begin
            mem_ready = 1'b0;
            wait_cnt = 0;
         end
         if (mem_req_valid) begin
            if (wait_cnt >= mem_lat) begin
               mem_ready = 1'b1;
               mem_rdata = mem_word(mem_addr);
               if (fetch_n < 16) fetch_log[fetch_n] = mem_addr;
               fetch_n++;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < LINES; i++) ref_valid[i] = 0;
      @(negedge clk);
   endtask

   // One read; junk!=0 keeps a stray request raised while waiting.
   task automatic access(input logic [31:0] a, input bit junk, input logic [31:0] junk_addr);
      int blk, idx, tg, waited;
      bit exp_miss;
      logic [31:0] base;
      blk = int'(a / BLK_BYTES);
      idx = blk % LINES;
      tg = blk / LINES;
      exp_miss = !(ref_valid[idx] && ref_tag[idx] == tg);
      base = a & ~(BLK_BYTES - 1);
      fetch_n = 0;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr = a;
      @(negedge clk);
      if (junk) req_addr = junk_addr; else req_valid = 1'b0;
      waited = 1;
      while (!resp_valid && waited < 200) begin
         // R7: busy while request in flight
         if (req_ready) chk(0, "R7 req_ready during service", 1, 0);
         @(negedge clk);
         waited++;
      end
      req_valid = 1'b0;
      chk(resp_valid, "R8 response arrives", resp_valid, 1);
      // R3 hit/miss decision; R9 conflicts follow from the same model
      chk(resp_miss == exp_miss, "R3 resp_miss", resp_miss, exp_miss);
      // R10 data
      chk(resp_data == mem_word(a), "R10 resp_data", resp_data, mem_word(a));
      if (!exp_miss) begin
         // R8 hit latency one cycle
         chk(waited == 1, "R8 hit latency", waited, 1);
         // R6 no traffic on hit
         chk(fetch_n == 0, "R6 no fetch on hit", fetch_n, 0);
      end else begin
         miss_total++;
         // R5 whole block, ascending
         chk(fetch_n == BLOCK_WORDS, "R5 fetch count", fetch_n, BLOCK_WORDS);
         for (int k = 0; k < BLOCK_WORDS && k < fetch_n; k++)
            chk(fetch_log[k] == base + 32'(4*k), "R5 fetch order", fetch_log[k], base + 32'(4*k));
         ref_valid[idx] = 1;
         ref_tag[idx] = tg;
      end
      @(negedge clk);
      // R8 single-cycle strobe
      chk(!resp_valid, "R8 strobe one cycle", resp_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R4 reset state
      chk(req_ready == 1'b1, "R4 req_ready after reset", req_ready, 1);
      chk(resp_valid == 1'b0, "R4 resp_valid after reset", resp_valid, 0);
      chk(mem_req_valid == 1'b0, "R4 mem_req_valid after reset", mem_req_valid, 0);

      // R6 locality string: words 0,1,2,3,4,3,4,15 -> 4 misses with 2-word blocks
      begin
         int seq [8] = '{0, 1, 2, 3, 4, 3, 4, 15};
         miss_total = 0;
         for (int i = 0; i < 8; i++) begin
            mem_lat = i % 4;
            access(32'(seq[i] * 4), 0, 0);
         end
         chk(miss_total == 4, "R6 locality miss count", miss_total, 4);
      end

      // R9 ping-pong: words 0 and 8 share index 0
      do_reset();
      miss_total = 0;
      for (int i = 0; i < 8; i++) access((i % 2 == 0) ? 32'h0 : 32'h20, 0, 0);
      chk(miss_total == 8, "R9 ping-pong all miss", miss_total, 8);

      // R1 byte offset ignored
      mem_lat = 1;
      access(32'h0000_0044, 0, 0);
      for (int b = 1; b < 4; b++) begin
         miss_total = 0;
         access(32'h0000_0044 + 32'(b), 0, 0);
         chk(miss_total == 0, "R1 byte offset hit", miss_total, 0);
      end

      // R2 sweep over 64 words, cold then warm, with varied tags
      do_reset();
      for (int pass = 0; pass < 2; pass++)
         for (int w = 0; w < 64; w++) begin
            mem_lat = (w + pass) % 3;
            access(32'(w * 4) + (pass == 1 ? 32'h0001_0000 : 32'h0), 0, 0);
         end
      // R2 high tag bits distinguish blocks
      access(32'h8000_0000, 0, 0);
      access(32'h0000_0000, 0, 0);

      // R7 stray request during refill is ignored
      do_reset();
      mem_lat = 2;
      access(32'h0000_0100, 1, 32'h0000_0208);
      chk(req_ready == 1'b1, "R7 idle after stray", req_ready, 1);
      miss_total = 0;
      access(32'h0000_0208, 0, 0);
      chk(miss_total == 1, "R7 stray left no entry", miss_total, 1);

      // R4 second reset invalidates
      access(32'h0000_0100, 0, 0);
      do_reset();
      miss_total = 0;
      access(32'h0000_0100, 0, 0);
      chk(miss_total == 1, "R4 miss after reset", miss_total, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule